// File: doc/BRIEF.md
# Audio Port Routing Crossbar

This block is a register-programmed switch between five external serial audio ports and three internal audio controllers. Each port carries a bit clock, a frame sync and two serial data lines. Every pin is modelled as three separate signals: an input, an output and an output enable. Each port has its own control register. That register chooses where the port's outgoing lines come from, either one of the controllers or the pins of another port. It also sets whether the port drives clock and frame (master) and whether each data line drives its pin.

On the controller side, each controller has an input-select register. It picks, independently, which port supplies its clock and frame, which port supplies data line 1 and which supplies data line 2. Several ports may select the same controller, which broadcasts one controller's stream to many ports. When two ports are joined, the master bit of each decides which one drives clock and frame. The block does not check that a routing is consistent; software owns that.

Routing is purely combinational from the register contents. Register access uses a simple word interface with a write strobe and a read strobe. Read data is registered and appears on the cycle after the read strobe.

Top module: `audio_xbar`

## Requirements
- R1: Asynchronous active-low reset clears every register and the read-data output to zero. With the reset values, every port routes controller 1, and all output enables are low.
- R2: The register map is as follows.
  - Port p control registers (p = 0..4) sit at byte offset 4·p.
  - Controller c input-select registers (c = 0..2) sit at 0x40 + 4·c.
  - A write stores only the defined fields. Reading a register returns them, with every other bit as zero.
  - A read strobe in cycle N places the data on `reg_rdata` after edge N. That data holds until the next read strobe. A read in the same cycle as a write returns the pre-write value.
- R3: Any other address is ignored on write and reads as zero. This covers unaligned offsets and offsets beyond the last port or controller register.
- R4: Port source-select field (bits 4:0) values 0, 1 and 2 route controller 1, 2 and 3. The port's bclk, fs, sd1 and sd2 outputs then equal that controller's outgoing lines.
- R5: Port source-select values 16 to 20 route peer ports 1 to 5. The port's outputs then equal that peer port's input pins, line for line.
- R6: For a defined source select, output enables follow the control bits. Bit 31 (1 = master) drives the bclk and fs enables. Bit 30 (1 = transmit) drives the sd1 enable, and bit 29 (1 = transmit) drives the sd2 enable.
- R7: Port source-select values 3 to 15 and 21 to 31 are undefined. They force all four outputs and all four output enables of that port to zero.
- R8: Each controller's input-select register chooses its inputs as follows.
  - Bits 3:0 choose the port whose bclk and fs feed the controller.
  - Bits 27:24 choose the port for sd1, and bits 31:28 choose the port for sd2.
  - Ports 1 to 5 are coded 0 to 4. Codes 5 to 15 drive that controller input to zero.
- R9: Any number of ports may select the same controller at once. Each of them carries that controller's lines.
- R10: A register value changes routing only from the clock edge that accepts the write. With no accepted write, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pin_bclk_i | input | 5 | Port bit clock pin inputs |
| pin_bclk_o | output | 5 | Port bit clock pin outputs |
| pin_bclk_oe | output | 5 | Port bit clock output enables |
| pin_fs_i | input | 5 | Port frame sync pin inputs |
| pin_fs_o | output | 5 | Port frame sync pin outputs |
| pin_fs_oe | output | 5 | Port frame sync output enables |
| pin_sd1_i | input | 5 | Port data line 1 pin inputs |
| pin_sd1_o | output | 5 | Port data line 1 pin outputs |
| pin_sd1_oe | output | 5 | Port data line 1 output enables |
| pin_sd2_i | input | 5 | Port data line 2 pin inputs |
| pin_sd2_o | output | 5 | Port data line 2 pin outputs |
| pin_sd2_oe | output | 5 | Port data line 2 output enables |
| ctl_bclk_tx | input | 3 | Bit clock sent by each controller toward ports |
| ctl_fs_tx | input | 3 | Frame sync sent by each controller |
| ctl_sd1_tx | input | 3 | Data line 1 sent by each controller |
| ctl_sd2_tx | input | 3 | Data line 2 sent by each controller |
| ctl_bclk_rx | output | 3 | Bit clock delivered to each controller |
| ctl_fs_rx | output | 3 | Frame sync delivered to each controller |
| ctl_sd1_rx | output | 3 | Data line 1 delivered to each controller |
| ctl_sd2_rx | output | 3 | Data line 2 delivered to each controller |

## Verification
The bench builds the block with its default sizes: five ports, three controllers, port registers from offset 0 and controller registers from 0x40. With these sizes, the full 5-bit port code space (8 defined, 24 undefined) and the 4-bit controller code space (5 defined, 11 undefined) are both small enough that random write data reaches every code many times. The undecoded gap between 0x14 and 0x3C, the first offsets past each bank and unaligned offsets sit close to valid ones, so decode slips at each bank edge show up. Random pin and controller line values change every cycle, so a wrong source choice shows at once against the behavioural model.

// File: rtl/axb_pkg.sv
package axb_pkg;

  localparam int WORD_W     = 32;
  localparam int PSEL_W     = 5;   // port source code width
  localparam int CSEL_W     = 4;   // controller port-select width
  localparam int PEER_BASE  = 16;  // first peer-port code in a port register
  localparam int REG_STRIDE = 4;

  // fixed bit positions, decoded by software
  localparam int MS_BIT     = 31;
  localparam int D1_BIT     = 30;
  localparam int D2_BIT     = 29;
  localparam int CS_SD2_LSB = 28;
  localparam int CS_SD1_LSB = 24;
  localparam int CS_CLK_LSB = 0;

  typedef struct packed {
    logic bclk;
    logic fs;
    logic sd1;
    logic sd2;
  } lines_t;

  typedef struct packed {
    logic              master;
    logic              dir1;
    logic              dir2;
    logic [PSEL_W-1:0] src;
  } port_cfg_t;

  typedef struct packed {
    logic [CSEL_W-1:0] sd2_sel;
    logic [CSEL_W-1:0] sd1_sel;
    logic [CSEL_W-1:0] clk_sel;
  } ctrl_cfg_t;

endpackage

// File: rtl/axb_regfile.sv
module axb_regfile
  import axb_pkg::*;
#(
  parameter int N_PORT    = 5,
  parameter int N_CTRL    = 3,
  parameter int ADDR_W    = 8,
  parameter int PORT_BASE = 'h00,
  parameter int CTRL_BASE = 'h40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [WORD_W-1:0]       reg_wdata,
  output logic [WORD_W-1:0]       reg_rdata,
  output port_cfg_t [N_PORT-1:0]  port_cfg,
  output ctrl_cfg_t [N_CTRL-1:0]  ctrl_cfg
);

  localparam int PORT_RSV_W = WORD_W - 3 - PSEL_W;
  localparam int CTRL_RSV_W = WORD_W - 3 * CSEL_W;

  logic [N_PORT-1:0] port_hit;
  logic [N_CTRL-1:0] ctrl_hit;
  logic              any_hit;

  port_cfg_t [N_PORT-1:0] port_q, port_nxt;
  ctrl_cfg_t [N_CTRL-1:0] ctrl_q, ctrl_nxt;
  logic [WORD_W-1:0]      rd_word;
  logic [WORD_W-1:0]      rdata_nxt;
  logic                   rdata_en;

  // address decode, one comparator per register
  for (genvar gp = 0; gp < N_PORT; gp++) begin : g_port_dec
    assign port_hit[gp] = (reg_addr == ADDR_W'(PORT_BASE + REG_STRIDE * gp));
  end
  for (genvar gc = 0; gc < N_CTRL; gc++) begin : g_ctrl_dec
    assign ctrl_hit[gc] = (reg_addr == ADDR_W'(CTRL_BASE + REG_STRIDE * gc));
  end
  assign any_hit = |{port_hit, ctrl_hit};

  // next state of configuration registers
  always_comb begin
    port_nxt = port_q;
    ctrl_nxt = ctrl_q;
    for (int i = 0; i < N_PORT; i++) begin
      if (reg_wr && port_hit[i]) begin
        port_nxt[i].master = reg_wdata[MS_BIT];
        port_nxt[i].dir1   = reg_wdata[D1_BIT];
        port_nxt[i].dir2   = reg_wdata[D2_BIT];
        port_nxt[i].src    = reg_wdata[PSEL_W-1:0];
      end
    end
    for (int j = 0; j < N_CTRL; j++) begin
      if (reg_wr && ctrl_hit[j]) begin
        ctrl_nxt[j].sd2_sel = reg_wdata[CS_SD2_LSB +: CSEL_W];
        ctrl_nxt[j].sd1_sel = reg_wdata[CS_SD1_LSB +: CSEL_W];
        ctrl_nxt[j].clk_sel = reg_wdata[CS_CLK_LSB +: CSEL_W];
      end
    end
  end

  // read mux: defined fields only, reserved bits zero
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N_PORT; i++) begin
      if (port_hit[i]) begin
        rd_word = rd_word | {port_q[i].master, port_q[i].dir1, port_q[i].dir2,
                             {PORT_RSV_W{1'b0}}, port_q[i].src};
      end
    end
    for (int j = 0; j < N_CTRL; j++) begin
      if (ctrl_hit[j]) begin
        rd_word = rd_word | {ctrl_q[j].sd2_sel, ctrl_q[j].sd1_sel,
                             {CTRL_RSV_W{1'b0}}, ctrl_q[j].clk_sel};
      end
    end
  end

  assign rdata_en  = reg_rd;
  assign rdata_nxt = rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      ctrl_q <= '0;
    end else begin
      port_q <= port_nxt;
      ctrl_q <= ctrl_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (rdata_en) begin
      reg_rdata <= rdata_nxt;
    end
  end

  assign port_cfg = port_q;
  assign ctrl_cfg = ctrl_q;

  // R10: no accepted write, no change to routing state
  a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(port_q) && $stable(ctrl_q)));

  // R3: writes that miss every register leave state alone
  a_r3_miss_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !any_hit) |=> ($stable(port_q) && $stable(ctrl_q)));

  // R3: reads that miss return zero on the next cycle
  a_r3_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !any_hit) |=> (reg_rdata == '0));

  // R2: read data holds without a read strobe
  a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

endmodule

// File: rtl/axb_port_route.sv
module axb_port_route
  import axb_pkg::*;
#(
  parameter int N_PORT = 5,
  parameter int N_CTRL = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  port_cfg_t [N_PORT-1:0] cfg,
  input  lines_t    [N_PORT-1:0] pin_in,
  input  lines_t    [N_CTRL-1:0] ctl_tx,
  output lines_t    [N_PORT-1:0] pin_out,
  output lines_t    [N_PORT-1:0] pin_oe
);

  for (genvar gp = 0; gp < N_PORT; gp++) begin : g_port
    lines_t sel_val;
    logic   sel_ok;

    always_comb begin
      sel_val = '0;
      sel_ok  = 1'b0;
      for (int c = 0; c < N_CTRL; c++) begin
        if (cfg[gp].src == PSEL_W'(c)) begin
          sel_val = ctl_tx[c];
          sel_ok  = 1'b1;
        end
      end
      for (int q = 0; q < N_PORT; q++) begin
        if (cfg[gp].src == PSEL_W'(PEER_BASE + q)) begin
          sel_val = pin_in[q];
          sel_ok  = 1'b1;
        end
      end
    end

    assign pin_out[gp] = sel_val;
    assign pin_oe[gp]  = sel_ok ? {cfg[gp].master, cfg[gp].master,
                                   cfg[gp].dir1, cfg[gp].dir2} : 4'b0000;

    // R6: a data enable never rises without its direction bit
    a_r6_sd1_oe_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[gp].sd1 |-> cfg[gp].dir1);
    a_r6_clk_oe_pair: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[gp].bclk == pin_oe[gp].fs);

    // R7: undefined codes leave the port silent
    a_r7_undefined_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[gp].src >= PSEL_W'(N_CTRL) && cfg[gp].src < PSEL_W'(PEER_BASE))
        |-> (pin_oe[gp] == '0 && pin_out[gp] == '0));

    // R4: code 0 carries the first controller's lines
    a_r4_first_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[gp].src == '0) |-> (pin_out[gp] == ctl_tx[0]));

    // R5: first peer code carries port 1's pins
    a_r5_first_peer: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[gp].src == PSEL_W'(PEER_BASE)) |-> (pin_out[gp] == pin_in[0]));
  end

endmodule

// File: rtl/axb_ctrl_route.sv
module axb_ctrl_route
  import axb_pkg::*;
#(
  parameter int N_PORT = 5,
  parameter int N_CTRL = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ctrl_cfg_t [N_CTRL-1:0] cfg,
  input  lines_t    [N_PORT-1:0] pin_in,
  output lines_t    [N_CTRL-1:0] ctl_rx
);

  for (genvar gc = 0; gc < N_CTRL; gc++) begin : g_ctrl
    lines_t sel_val;

    always_comb begin
      sel_val = '0;
      for (int q = 0; q < N_PORT; q++) begin
        if (cfg[gc].clk_sel == CSEL_W'(q)) begin
          sel_val.bclk = pin_in[q].bclk;
          sel_val.fs   = pin_in[q].fs;
        end
        if (cfg[gc].sd1_sel == CSEL_W'(q)) begin
          sel_val.sd1 = pin_in[q].sd1;
        end
        if (cfg[gc].sd2_sel == CSEL_W'(q)) begin
          sel_val.sd2 = pin_in[q].sd2;
        end
      end
    end

    assign ctl_rx[gc] = sel_val;

    // R8: an out-of-range clock select starves the controller's clock and frame
    a_r8_clk_sel_undefined: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[gc].clk_sel >= CSEL_W'(N_PORT)) |-> (!ctl_rx[gc].bclk && !ctl_rx[gc].fs));

    // R8: data line 2 follows the selected port when in range
    a_r8_sd2_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[gc].sd2_sel == '0) |-> (ctl_rx[gc].sd2 == pin_in[0].sd2));
  end

endmodule

// File: rtl/audio_xbar.sv
module audio_xbar
  import axb_pkg::*;
#(
  parameter int N_PORT    = 5,
  parameter int N_CTRL    = 3,
  parameter int ADDR_W    = 8,
  parameter int PORT_BASE = 'h00,
  parameter int CTRL_BASE = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [N_PORT-1:0] pin_bclk_i,
  output logic [N_PORT-1:0] pin_bclk_o,
  output logic [N_PORT-1:0] pin_bclk_oe,
  input  logic [N_PORT-1:0] pin_fs_i,
  output logic [N_PORT-1:0] pin_fs_o,
  output logic [N_PORT-1:0] pin_fs_oe,
  input  logic [N_PORT-1:0] pin_sd1_i,
  output logic [N_PORT-1:0] pin_sd1_o,
  output logic [N_PORT-1:0] pin_sd1_oe,
  input  logic [N_PORT-1:0] pin_sd2_i,
  output logic [N_PORT-1:0] pin_sd2_o,
  output logic [N_PORT-1:0] pin_sd2_oe,
  input  logic [N_CTRL-1:0] ctl_bclk_tx,
  input  logic [N_CTRL-1:0] ctl_fs_tx,
  input  logic [N_CTRL-1:0] ctl_sd1_tx,
  input  logic [N_CTRL-1:0] ctl_sd2_tx,
  output logic [N_CTRL-1:0] ctl_bclk_rx,
  output logic [N_CTRL-1:0] ctl_fs_rx,
  output logic [N_CTRL-1:0] ctl_sd1_rx,
  output logic [N_CTRL-1:0] ctl_sd2_rx
);

  port_cfg_t [N_PORT-1:0] port_cfg;
  ctrl_cfg_t [N_CTRL-1:0] ctrl_cfg;
  lines_t    [N_PORT-1:0] pin_in, pin_out, pin_oe;
  lines_t    [N_CTRL-1:0] ctl_tx, ctl_rx;

  for (genvar gp = 0; gp < N_PORT; gp++) begin : g_pin_pack
    assign pin_in[gp]      = {pin_bclk_i[gp], pin_fs_i[gp], pin_sd1_i[gp], pin_sd2_i[gp]};
    assign pin_bclk_o[gp]  = pin_out[gp].bclk;
    assign pin_fs_o[gp]    = pin_out[gp].fs;
    assign pin_sd1_o[gp]   = pin_out[gp].sd1;
    assign pin_sd2_o[gp]   = pin_out[gp].sd2;
    assign pin_bclk_oe[gp] = pin_oe[gp].bclk;
    assign pin_fs_oe[gp]   = pin_oe[gp].fs;
    assign pin_sd1_oe[gp]  = pin_oe[gp].sd1;
    assign pin_sd2_oe[gp]  = pin_oe[gp].sd2;
  end

  for (genvar gc = 0; gc < N_CTRL; gc++) begin : g_ctl_pack
    assign ctl_tx[gc]      = {ctl_bclk_tx[gc], ctl_fs_tx[gc], ctl_sd1_tx[gc], ctl_sd2_tx[gc]};
    assign ctl_bclk_rx[gc] = ctl_rx[gc].bclk;
    assign ctl_fs_rx[gc]   = ctl_rx[gc].fs;
    assign ctl_sd1_rx[gc]  = ctl_rx[gc].sd1;
    assign ctl_sd2_rx[gc]  = ctl_rx[gc].sd2;
  end

  axb_regfile #(
    .N_PORT(N_PORT), .N_CTRL(N_CTRL), .ADDR_W(ADDR_W),
    .PORT_BASE(PORT_BASE), .CTRL_BASE(CTRL_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .port_cfg(port_cfg), .ctrl_cfg(ctrl_cfg)
  );

  axb_port_route #(.N_PORT(N_PORT), .N_CTRL(N_CTRL)) u_port_route (
    .clk(clk), .rst_n(rst_n),
    .cfg(port_cfg), .pin_in(pin_in), .ctl_tx(ctl_tx),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  axb_ctrl_route #(.N_PORT(N_PORT), .N_CTRL(N_CTRL)) u_ctrl_route (
    .clk(clk), .rst_n(rst_n),
    .cfg(ctrl_cfg), .pin_in(pin_in), .ctl_rx(ctl_rx)
  );

  // R1: while reset is applied every output enable is low
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!rst_n -> (pin_bclk_oe == '0 && pin_sd1_oe == '0 && pin_sd2_oe == '0)));

endmodule

// File: tb/audio_xbar_test.sv
`timescale 1ns/1ps
module audio_xbar_test;

  localparam int NP = 5;
  localparam int NC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] pin_bclk_i = '0, pin_fs_i = '0, pin_sd1_i = '0, pin_sd2_i = '0;
  logic [NP-1:0] pin_bclk_o, pin_fs_o, pin_sd1_o, pin_sd2_o;
  logic [NP-1:0] pin_bclk_oe, pin_fs_oe, pin_sd1_oe, pin_sd2_oe;
  logic [NC-1:0] ctl_bclk_tx = '0, ctl_fs_tx = '0, ctl_sd1_tx = '0, ctl_sd2_tx = '0;
  logic [NC-1:0] ctl_bclk_rx, ctl_fs_rx, ctl_sd1_rx, ctl_sd2_rx;

  always #2.5 clk = ~clk;

  audio_xbar #(.N_PORT(NP), .N_CTRL(NC)) uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_bclk_i(pin_bclk_i), .pin_bclk_o(pin_bclk_o), .pin_bclk_oe(pin_bclk_oe),
    .pin_fs_i(pin_fs_i), .pin_fs_o(pin_fs_o), .pin_fs_oe(pin_fs_oe),
    .pin_sd1_i(pin_sd1_i), .pin_sd1_o(pin_sd1_o), .pin_sd1_oe(pin_sd1_oe),
    .pin_sd2_i(pin_sd2_i), .pin_sd2_o(pin_sd2_o), .pin_sd2_oe(pin_sd2_oe),
    .ctl_bclk_tx(ctl_bclk_tx), .ctl_fs_tx(ctl_fs_tx),
    .ctl_sd1_tx(ctl_sd1_tx), .ctl_sd2_tx(ctl_sd2_tx),
    .ctl_bclk_rx(ctl_bclk_rx), .ctl_fs_rx(ctl_fs_rx),
    .ctl_sd1_rx(ctl_sd1_rx), .ctl_sd2_rx(ctl_sd2_rx)
  );

  // behavioural reference state
  logic [31:0] mp [NP];
  logic [31:0] mc [NC];
  logic [31:0] exp_rdata = '0;
  bit          last_rd_ok = 1'b1;
  bit          pend_wr = 0, pend_rd = 0;
  logic [7:0]  pend_addr = '0;
  logic [31:0] pend_data = '0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  function automatic bit addr_ok(input logic [7:0] a);
    if (a[1:0] != 2'b00) return 0;
    if (a < 8'(4 * NP)) return 1;
    if (a >= 8'h40 && a < 8'(64 + 4 * NC)) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] mread(input logic [7:0] a);
    if (!addr_ok(a)) return '0;
    if (a < 8'h40) return mp[a / 4];
    return mc[(a - 8'h40) / 4];
  endfunction

  task automatic mwrite(input logic [7:0] a, input logic [31:0] d);
    if (!addr_ok(a)) return;
    if (a < 8'h40) mp[a / 4] = d & 32'hE000_001F;
    else           mc[(a - 8'h40) / 4] = d & 32'hFF00_000F;
  endtask

  task automatic compare_all();
    for (int p = 0; p < NP; p++) begin
      int src = int'(mp[p][4:0]);
      logic [3:0] ev = 4'b0, eo = 4'b0;
      string tv, to;
      if (src < NC) begin
        ev = {ctl_bclk_tx[src], ctl_fs_tx[src], ctl_sd1_tx[src], ctl_sd2_tx[src]};
        tv = "R4"; to = "R6";
      end else if (src >= 16 && src < 16 + NP) begin
        ev = {pin_bclk_i[src-16], pin_fs_i[src-16], pin_sd1_i[src-16], pin_sd2_i[src-16]};
        tv = "R5"; to = "R6";
      end else begin
        tv = "R7"; to = "R7";
      end
      if (tv != "R7") eo = {mp[p][31], mp[p][31], mp[p][30], mp[p][29]};
      chk(tv, 32'({pin_bclk_o[p], pin_fs_o[p], pin_sd1_o[p], pin_sd2_o[p]}), 32'(ev));
      chk(to, 32'({pin_bclk_oe[p], pin_fs_oe[p], pin_sd1_oe[p], pin_sd2_oe[p]}), 32'(eo));
    end
    for (int c = 0; c < NC; c++) begin
      int ck = int'(mc[c][3:0]);
      int d1 = int'(mc[c][27:24]);
      int d2 = int'(mc[c][31:28]);
      logic [3:0] ev;
      ev[3] = (ck < NP) ? pin_bclk_i[ck] : 1'b0;
      ev[2] = (ck < NP) ? pin_fs_i[ck]   : 1'b0;
      ev[1] = (d1 < NP) ? pin_sd1_i[d1]  : 1'b0;
      ev[0] = (d2 < NP) ? pin_sd2_i[d2]  : 1'b0;
      chk("R8", 32'({ctl_bclk_rx[c], ctl_fs_rx[c], ctl_sd1_rx[c], ctl_sd2_rx[c]}), 32'(ev));
    end
    chk(last_rd_ok ? "R2" : "R3", reg_rdata, exp_rdata);
  endtask

  task automatic shuffle();
    pin_bclk_i = NP'($urandom); pin_fs_i = NP'($urandom);
    pin_sd1_i  = NP'($urandom); pin_sd2_i = NP'($urandom);
    ctl_bclk_tx = NC'($urandom); ctl_fs_tx = NC'($urandom);
    ctl_sd1_tx  = NC'($urandom); ctl_sd2_tx = NC'($urandom);
  endtask

  // advance one cycle: commit the op applied last cycle, then compare
  task automatic step();
    @(negedge clk);
    if (pend_rd) begin
      exp_rdata  = mread(pend_addr);
      last_rd_ok = addr_ok(pend_addr);
    end
    if (pend_wr) mwrite(pend_addr, pend_data);
    pend_wr = 0; pend_rd = 0;
    reg_wr = 1'b0; reg_rd = 1'b0;
    compare_all();
  endtask

  task automatic op(input bit wr, input bit rd, input logic [7:0] a, input logic [31:0] d);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    pend_wr = wr; pend_rd = rd; pend_addr = a; pend_data = d;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    op(1, 0, a, d); step();
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] e);
    op(0, 1, a, 32'h0); step();
    chk(req, reg_rdata, e);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    for (int i = 0; i < NP; i++) mp[i] = '0;
    for (int i = 0; i < NC; i++) mc[i] = '0;
    shuffle();
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk("R1", reg_rdata, 32'h0);
    chk("R1", 32'(pin_bclk_oe | pin_fs_oe | pin_sd1_oe | pin_sd2_oe), 32'h0);
    chk("R1", 32'({pin_bclk_o[4], pin_sd1_o[4]}), 32'({ctl_bclk_tx[0], ctl_sd1_tx[0]}));
    rst_n = 1'b1;
    step();
    for (int i = 0; i < NP; i++) rd_chk("R1", 8'(4 * i), 32'h0);
    for (int i = 0; i < NC; i++) rd_chk("R1", 8'(64 + 4 * i), 32'h0);

    // R2: reserved bits drop, defined fields read back
    wr(8'h00, 32'hFFFF_FFF1);
    rd_chk("R2", 8'h00, 32'hE000_0011);
    wr(8'h44, 32'hFFFF_FFFF);
    rd_chk("R2", 8'h44, 32'hFF00_000F);
    // R2: read in the same cycle as a write gives the old value
    op(1, 1, 8'h00, 32'h0000_0002); step();
    chk("R2", reg_rdata, 32'hE000_0011);
    rd_chk("R2", 8'h00, 32'h0000_0002);

    // R3: invalid offsets
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    wr(8'h42, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd_chk("R3", 8'h14, 32'h0);
    rd_chk("R3", 8'h4C, 32'h0);
    rd_chk("R3", 8'h01, 32'h0);
    rd_chk("R3", 8'h00, 32'h0000_0002);
    rd_chk("R3", 8'h40, 32'h0);

    // R5 / R6: port 2 loops from port 4 as master with both data lines out
    wr(8'h08, 32'hE000_0014);
    repeat (4) begin shuffle(); step(); end
    chk("R5", 32'({pin_bclk_o[2], pin_sd2_o[2]}), 32'({pin_bclk_i[4], pin_sd2_i[4]}));
    chk("R6", 32'({pin_fs_oe[2], pin_sd1_oe[2], pin_sd2_oe[2]}), 32'h7);

    // R7: undefined port codes, R8: undefined controller selects
    wr(8'h0C, 32'hE000_0005);
    wr(8'h10, 32'hE000_0015);
    wr(8'h48, 32'h5540_0005);
    repeat (4) begin shuffle(); step(); end
    chk("R7", 32'({pin_bclk_oe[3], pin_sd1_oe[4], pin_bclk_o[3], pin_sd2_o[4]}), 32'h0);
    chk("R8", 32'({ctl_bclk_rx[2], ctl_fs_rx[2], ctl_sd1_rx[2], ctl_sd2_rx[2]}), 32'h0);

    // R9: broadcast controller 3 to every port
    for (int i = 0; i < NP; i++) wr(8'(4 * i), 32'h8000_0002);
    repeat (6) begin
      shuffle(); step();
      for (int i = 0; i < NP; i++)
        chk("R9", 32'({pin_bclk_o[i], pin_fs_o[i], pin_sd1_o[i], pin_sd2_o[i], pin_bclk_oe[i]}),
            32'({ctl_bclk_tx[2], ctl_fs_tx[2], ctl_sd1_tx[2], ctl_sd2_tx[2], 1'b1}));
    end

    // R10: a write changes routing only after its edge
    wr(8'h00, 32'h0000_0000);
    op(1, 0, 8'h00, 32'h8000_0000);
    #1;
    chk("R10", 32'(pin_bclk_oe[0]), 32'h0);
    step();
    chk("R10", 32'(pin_bclk_oe[0]), 32'h1);

    // random traffic, compared every cycle
    for (int n = 0; n < 4000; n++) begin
      int sel = int'($urandom % 6);
      logic [7:0]  a;
      logic [31:0] d = $urandom;
      case (sel)
        0, 1: a = 8'(4 * ($urandom % NP));
        2:    a = 8'(64 + 4 * ($urandom % NC));
        3:    a = 8'($urandom);
        4:    a = ($urandom % 2) ? 8'(4 * NP) : 8'(64 + 4 * NC);
        default: a = 8'(4 * ($urandom % NP) + 1 + ($urandom % 3));
      endcase
      if ($urandom % 2) d[4:0] = ($urandom % 2) ? 5'($urandom % NC) : 5'(16 + $urandom % NP);
      if ($urandom % 2) d[27:24] = 4'($urandom % NP);
      shuffle();
      op(($urandom % 3) == 0, ($urandom % 3) == 0, a, d);
      step();
    end
    step();
    finish_up();
  end

endmodule